// File: doc/BRIEF.md
# Microprogram Address Sequencer with Front-Panel Load

This block holds the 10-bit microprogram address of a small microcoded processor. The address is an 8-bit position within a 256-word page plus a 2-bit page number. In run mode every rising clock edge moves the address forward. The move is one step by default, two steps when a skip is requested, or straight to a supplied target when a jump is requested.

In panel mode the run requests are not used. Instead, a 16-bit command word from the operator switches is decoded. Four opcode bytes each name one of the four pages, and the low byte of the command carries the in-page literal. A matching command stores the page-qualified literal plus one, and any other command leaves the address alone. The microcode store and the condition logic sit outside the block. Skip and jump reach it as plain request inputs.

Each clock edge performs exactly one action, chosen by priority. The actions are named HOLD, STEP, SKIP, JUMP and LOAD, and the address register moves as the chosen action directs. Reset overrides every action. The transitions work as follows:
- In run mode, JUMP is taken when a jump is requested, SKIP when only a skip is requested, and STEP otherwise.
- In panel mode, LOAD is taken on a recognised command and HOLD on anything else.

Top module: `upc_addr_seq`

## Requirements
- R1: Reset is synchronous and active high. At a rising edge with `rst` high, the address becomes 0x000 whatever the other inputs are.
- R2: In run mode (`panel_en` low) with neither request active, each rising edge adds one to the address.
- R3: Address arithmetic is modulo 1024. A step from 0x3FF gives 0x000, and a skip from 0x3FF gives 0x001.
- R4: In run mode with `skip_req` high and `jump_req` low, the address advances by two.
- R5: In run mode with `jump_req` high, the address becomes `jump_tgt`, whatever the value of `skip_req`.
- R6: In panel mode, a command whose upper byte is 0x14, 0x15, 0x1C or 0x1D selects page 0, 1, 2 or 3 respectively. The address then becomes (page × 256 + `cmd[7:0]`) + 1 modulo 1024. For example, 0x14A9 gives 0x0AA, 0x1DED gives 0x3EE, and 0x15FF gives 0x200.
- R7: In panel mode, any command whose upper byte is none of the four load codes leaves the address unchanged. `skip_req`, `jump_req` and `jump_tgt` have no effect in panel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one operator clock press or one run step |
| rst | input | 1 | Synchronous active-high reset |
| panel_en | input | 1 | High selects panel mode, low selects run mode |
| cmd | input | 16 | Panel command word |
| skip_req | input | 1 | Run-mode request to advance by two |
| jump_req | input | 1 | Run-mode request to load the jump target |
| jump_tgt | input | 10 | Jump target address |
| addr | output | 10 | Current microprogram address |

## Verification
The bench checks the +1 on panel loads. A design that dropped it would show 0x0A9 for 0x14A9. It also checks the carry of that +1 into the page bits: a 0x15FF load must give 0x200, and 0x1DFF must wrap to 0x000. A design that truncated the carry would stay in the old page. Wrap-around on step and skip from 0x3FF is checked, along with jump winning over a simultaneous skip; a wrong priority would give target+2 or the old address+2. Panel mode is driven with non-load commands and with active jump and skip requests. A leaky decoder would then move the address, which the bench would see on the output.

// File: rtl/upc_pkg.sv
package upc_pkg;

    localparam int PAGE_W = 2;
    localparam int SKIP_STRIDE = 2;

    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_STEP = 3'd1,
        ACT_SKIP = 3'd2,
        ACT_JUMP = 3'd3,
        ACT_LOAD = 3'd4
    } upc_act_e;

endpackage

// File: rtl/upc_panel_dec.sv
module upc_panel_dec
    import upc_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int LIT_W = 8
) (
    input  logic [CMD_W-1:0]        cmd_i,
    output logic                    hit_o,
    output logic [PAGE_W+LIT_W-1:0] base_o
);
    localparam int OP_W = CMD_W - LIT_W;

    logic [OP_W-1:0]   op;
    logic [PAGE_W-1:0] page;

    assign op = cmd_i[CMD_W-1:LIT_W];

    always_comb begin
        hit_o = (op[OP_W-1:OP_W-4] == 4'h1) && (op[2:1] == 2'b10);
        page  = {op[3], op[0]};
        base_o = {page, cmd_i[LIT_W-1:0]};
    end

endmodule

// File: rtl/upc_act_sel.sv
module upc_act_sel
    import upc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     panel_en_i,
    input  logic     load_hit_i,
    input  logic     jump_req_i,
    input  logic     skip_req_i,
    output upc_act_e act_o
);

    always_comb begin
        if (panel_en_i) begin
            act_o = load_hit_i ? ACT_LOAD : ACT_HOLD;
        end else if (jump_req_i) begin
            act_o = ACT_JUMP;
        end else if (skip_req_i) begin
            act_o = ACT_SKIP;
        end else begin
            act_o = ACT_STEP;
        end
    end

    // R5: jump outranks skip in run mode
    assert_jump_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (!panel_en_i && jump_req_i && skip_req_i) |-> (act_o == ACT_JUMP));

    // R7: run requests never pick a run action in panel mode
    assert_panel_no_run_R7: assert property (@(posedge clk) disable iff (rst)
        panel_en_i |-> (act_o != ACT_JUMP && act_o != ACT_SKIP && act_o != ACT_STEP));

endmodule

// File: rtl/upc_addr_reg.sv
module upc_addr_reg
    import upc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  upc_act_e          act_i,
    input  logic [ADDR_W-1:0] load_base_i,
    input  logic [ADDR_W-1:0] jump_tgt_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] SKIP = ADDR_W'(SKIP_STRIDE);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    always_comb begin
        addr_d = addr_q;
        unique case (act_i)
            ACT_HOLD: addr_d = addr_q;
            ACT_STEP: addr_d = addr_q + ONE;
            ACT_SKIP: addr_d = addr_q + SKIP;
            ACT_JUMP: addr_d = jump_tgt_i;
            ACT_LOAD: addr_d = load_base_i + ONE;
            default:  addr_d = addr_q;
        endcase
    end

    assign addr_o = addr_q;

    // R3: a step from the top address lands on zero
    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (act_i == ACT_STEP && addr_q == '1) |=> (addr_q == '0));

endmodule

// File: rtl/upc_addr_seq.sv
module upc_addr_seq
    import upc_pkg::*;
#(
    parameter int LIT_W = 8,
    parameter int CMD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    panel_en,
    input  logic [CMD_W-1:0]        cmd,
    input  logic                    skip_req,
    input  logic                    jump_req,
    input  logic [PAGE_W+LIT_W-1:0] jump_tgt,
    output logic [PAGE_W+LIT_W-1:0] addr
);
    localparam int ADDR_W = PAGE_W + LIT_W;

    logic              load_hit;
    logic [ADDR_W-1:0] load_base;
    upc_act_e          act;

    upc_panel_dec #(.CMD_W(CMD_W), .LIT_W(LIT_W)) u_dec (
        .cmd_i  (cmd),
        .hit_o  (load_hit),
        .base_o (load_base)
    );

    upc_act_sel u_sel (
        .clk        (clk),
        .rst        (rst),
        .panel_en_i (panel_en),
        .load_hit_i (load_hit),
        .jump_req_i (jump_req),
        .skip_req_i (skip_req),
        .act_o      (act)
    );

    upc_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk         (clk),
        .rst         (rst),
        .act_i       (act),
        .load_base_i (load_base),
        .jump_tgt_i  (jump_tgt),
        .addr_o      (addr)
    );

    // R1: reset clears the address on the following edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (addr == '0));

    // R2: plain run step adds one
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!panel_en && !jump_req && !skip_req) |=> (addr == ADDR_W'($past(addr) + ADDR_W'(1))));

    // R4: skip advances by two
    assert_skip_R4: assert property (@(posedge clk) disable iff (rst)
        (!panel_en && !jump_req && skip_req) |=> (addr == ADDR_W'($past(addr) + ADDR_W'(2))));

    // R5: jump takes the target
    assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
        (!panel_en && jump_req) |=> (addr == $past(jump_tgt)));

    // R6: page 3 load stores literal plus one
    assert_load_page3_R6: assert property (@(posedge clk) disable iff (rst)
        (panel_en && cmd[CMD_W-1:LIT_W] == 8'h1D) |=>
        (addr == ADDR_W'({2'b11, $past(cmd[LIT_W-1:0])} + ADDR_W'(1))));

    // R7: a non-load panel command holds the address
    assert_panel_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (panel_en && cmd[CMD_W-1:LIT_W] != 8'h14 && cmd[CMD_W-1:LIT_W] != 8'h15 &&
         cmd[CMD_W-1:LIT_W] != 8'h1C && cmd[CMD_W-1:LIT_W] != 8'h1D) |=> $stable(addr));

endmodule

// File: tb/sim_upc_addr_seq.sv
module sim_upc_addr_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        panel_en = 1'b0;
    logic [15:0] cmd = 16'h0000;
    logic        skip_req = 1'b0;
    logic        jump_req = 1'b0;
    logic [9:0]  jump_tgt = 10'h000;
    logic [9:0]  addr;

    typedef struct {
        logic [9:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    logic [9:0] model = 10'h000;
    bit done = 1'b0;

    always #2 clk = ~clk;

    upc_addr_seq u0 (
        .clk      (clk),
        .rst      (rst),
        .panel_en (panel_en),
        .cmd      (cmd),
        .skip_req (skip_req),
        .jump_req (jump_req),
        .jump_tgt (jump_tgt),
        .addr     (addr)
    );

    task automatic drive(input logic r, input logic p, input logic [15:0] c,
                         input logic s, input logic j, input logic [9:0] t,
                         input logic [9:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; panel_en = p; cmd = c; skip_req = s; jump_req = j; jump_tgt = t;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic do_reset(input string tag);
        model = 10'h000;
        drive(1'b1, 1'b0, 16'h1DED, 1'b1, 1'b1, 10'h2AA, model, tag);
    endtask

    task automatic run_step(input string tag);
        model = model + 10'd1;
        drive(1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 10'h000, model, tag);
    endtask

    task automatic run_skip(input string tag);
        model = model + 10'd2;
        drive(1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 10'h000, model, tag);
    endtask

    task automatic run_jump(input logic [9:0] t, input logic s, input string tag);
        model = t;
        drive(1'b0, 1'b0, 16'h0000, s, 1'b1, t, model, tag);
    endtask

    task automatic panel(input logic [15:0] c, input logic s, input logic j, input string tag);
        logic [1:0] pg;
        bit hit;
        hit = 1'b1;
        case (c[15:8])
            8'h14: pg = 2'd0;
            8'h15: pg = 2'd1;
            8'h1C: pg = 2'd2;
            8'h1D: pg = 2'd3;
            default: begin pg = 2'd0; hit = 1'b0; end
        endcase
        if (hit) model = {pg, c[7:0]} + 10'd1;
        drive(1'b0, 1'b1, c, s, j, 10'h155, model, tag);
    endtask

    // monitor: pops one expectation per edge, samples 1 ns after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (addr !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr=%03h expected=%03h", it.tag, addr, it.exp);
                end
            end
        end
    end

    initial begin
        do_reset("R1 reset");
        do_reset("R1 reset hold");
        run_step("R2 step 1");
        run_step("R2 step 2");
        run_step("R2 step 3");
        run_skip("R4 skip");
        run_jump(10'h3FE, 1'b1, "R5 jump beats skip");
        run_step("R2 step to top");
        run_step("R3 step wraps");
        run_jump(10'h3FF, 1'b0, "R5 jump");
        run_skip("R3 skip wraps");
        panel(16'h14A9, 1'b0, 1'b0, "R6 page0 load");
        panel(16'h1454, 1'b0, 1'b0, "R6 page0 load 2");
        panel(16'h15FE, 1'b0, 1'b0, "R6 page1 load");
        panel(16'h1C10, 1'b0, 1'b0, "R6 page2 load");
        panel(16'h1DED, 1'b0, 1'b0, "R6 page3 load");
        panel(16'h15FF, 1'b0, 1'b0, "R6 carry into page");
        panel(16'h1DFF, 1'b0, 1'b0, "R6 carry wraps");
        panel(16'h1C7F, 1'b0, 1'b0, "R6 page2 load 2");
        panel(16'h1255, 1'b0, 1'b0, "R7 other cmd holds");
        panel(16'h16AA, 1'b0, 1'b0, "R7 near code holds");
        panel(16'h24A9, 1'b0, 1'b0, "R7 wrong nibble holds");
        panel(16'h1000, 1'b1, 1'b1, "R7 run reqs ignored");
        panel(16'h1000, 1'b1, 1'b0, "R7 skip ignored");
        run_step("R2 step after panel");
        run_skip("R4 skip after panel");
        do_reset("R1 reset mid-run");
        run_step("R2 step after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule